// File: doc/BRIEF.md
# One-Time Lower-Half Write Lock Controller

This block sits between the bus front end of a serial memory and its storage array, and decides whether each array write may commit. It combines two kinds of protection: a pin that makes the whole array read-only while it is high, and a one-time lock that makes a fixed low address range read-only for good. The lock is set by a dedicated command. The host addresses the device with a special device code and the write direction, then sends a dummy word address, a dummy data byte and a Stop. The pin must stay low for the whole of that transaction. Completing the command runs an internal commit period. The lock flag sets when that period ends.

The front end delivers decoded strobes: a received device-address byte, a word-address byte, a data byte, Start and Stop. For each device-address byte that carries the special code and this device's strap value, the block returns an acknowledge decision one cycle later. That decision also serves as a status query: an acknowledge means the lock is not yet set. The lock flag is cleared only by the initial (power-on) reset. The functional reset leaves it alone.

Top module: `perm_lock_ctrl`

## Requirements
- R1: After the initial reset `por_n`, `locked` is 0. After the functional reset `rst_n`, `busy` and `rsp_vld` are 0.
- R2: A device-address byte is special when bits [7:4] equal DEV_CODE (default 0110) and bits [3:1] equal `dev_strap`. Bit [0] is the direction, and 0 means write. Exactly one cycle after `addr_vld` with a special byte, `rsp_vld` pulses for one cycle. Any other byte produces no pulse.
- R3: With a response, `rsp_ack` is 1 only if the lock is clear and no commit period is running. This holds for both directions. A direction-1 query changes neither `locked` nor `busy`.
- R4: An acknowledged special write, followed by a word byte, then a data byte, then Stop, makes `busy` 1 from the cycle after Stop for WR_CYCLES cycles (default 20). `locked` becomes 1 in the cycle `busy` falls.
- R5: The command is abandoned without `busy` or a lock in any of these cases: a Stop before the data byte, a Start, or any new device-address byte before the Stop.
- R6: If `wp_pin` is high in any cycle from the special address through the Stop, including the Stop cycle itself, the command does not start a commit and does not set the lock.
- R7: While `wp_pin` is high, `arr_wr_en` is 0 for every address.
- R8: With `wp_pin` low, no commit running and the lock set, `arr_wr_en` is 0 for addresses below PROT_LIMIT (default 128). It equals `wr_req` for all other addresses. With the lock clear, it equals `wr_req` for every address.
- R9: While `busy` is 1, `arr_wr_en` is 0 and a special address is answered with `rsp_ack` 0.
- R10: `locked` stays 1 through any functional reset and any bus activity. Only `por_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Initial reset, active low, clears the lock |
| rst_n | input | 1 | Functional reset, active low |
| dev_strap | input | 3 | Device select strap value |
| wp_pin | input | 1 | Write-protect pin, high protects the whole array |
| addr_vld | input | 1 | Device-address byte strobe |
| addr_byte | input | 8 | Received device-address byte |
| word_vld | input | 1 | Word-address byte strobe |
| data_vld | input | 1 | Data byte strobe |
| stop_det | input | 1 | Stop condition strobe |
| start_det | input | 1 | Start condition strobe |
| wr_req | input | 1 | Array commit request |
| wr_addr | input | AW | Array commit address |
| rsp_vld | output | 1 | Response valid for a special address |
| rsp_ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| arr_wr_en | output | 1 | Gated array write enable |
| busy | output | 1 | Lock commit period running |
| locked | output | 1 | Sticky lock flag |

## Verification
Two functions can fall in the same cycle here. The first is completing the lock command on Stop. The second is the protect pin rising, which must cancel that command. The bench raises `wp_pin` in exactly the Stop cycle and expects `busy` to stay 0 one cycle later. A second overlap is a status query or an array commit request arriving during the commit period. The bench issues both in the middle of that period and expects no acknowledge and a closed gate, with `locked` rising only on the last busy cycle.

// File: rtl/plk_pkg.sv
package plk_pkg;
   typedef enum logic [1:0] {
      CS_IDLE = 2'd0,
      CS_DEV  = 2'd1,
      CS_WORD = 2'd2,
      CS_DATA = 2'd3
   } cmd_st_e;

   localparam int DEV_BYTE_W = 8;
   localparam int STRAP_W    = 3;
   localparam int CODE_W     = 4;
endpackage

// File: rtl/plk_addr_dec.sv
module plk_addr_dec
   import plk_pkg::*;
#(
   parameter logic [CODE_W-1:0] DEV_CODE = 4'b0110
) (
   input  logic [DEV_BYTE_W-1:0] addr_byte,
   input  logic [STRAP_W-1:0]    dev_strap,
   output logic                  hit,
   output logic                  is_wr
);
   localparam int CODE_LSB = DEV_BYTE_W - CODE_W;

   logic code_ok;
   logic strap_ok;

   always_comb begin
      code_ok  = (addr_byte[DEV_BYTE_W-1:CODE_LSB] == DEV_CODE);
      strap_ok = (addr_byte[CODE_LSB-1:1] == dev_strap);
      hit      = code_ok && strap_ok;
      is_wr    = ~addr_byte[0];
   end
endmodule

// File: rtl/plk_cmd_seq.sv
module plk_cmd_seq
   import plk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic addr_vld,
   input  logic hit,
   input  logic is_wr,
   input  logic ack_ok,
   input  logic word_vld,
   input  logic data_vld,
   input  logic stop_det,
   input  logic start_det,
   input  logic wp_pin,
   output logic burn_go
);
   cmd_st_e st, st_nxt;
   logic    taint, taint_nxt;

   always_comb begin
      st_nxt    = st;
      taint_nxt = taint;
      burn_go   = 1'b0;
      if (start_det) begin
         st_nxt = CS_IDLE;
      end else if (addr_vld) begin
         if (hit && is_wr && ack_ok) begin
            st_nxt    = CS_DEV;
            taint_nxt = wp_pin;
         end else begin
            st_nxt = CS_IDLE;
         end
      end else if (stop_det) begin
         burn_go = (st == CS_DATA) && !taint && !wp_pin;
         st_nxt  = CS_IDLE;
      end else begin
         if (st != CS_IDLE && wp_pin) taint_nxt = 1'b1;
         if (word_vld) begin
            st_nxt = (st == CS_DEV) ? CS_WORD : CS_IDLE;
         end else if (data_vld) begin
            st_nxt = (st == CS_WORD || st == CS_DATA) ? CS_DATA : CS_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= CS_IDLE;
         taint <= 1'b0;
      end else begin
         st    <= st_nxt;
         taint <= taint_nxt;
      end
   end

   // R6
   wp_taint_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CS_DATA && wp_pin && !start_det && !addr_vld && !stop_det) |=> (st == CS_IDLE || taint));

   // R5
   stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && st != CS_DATA) |-> !burn_go);
endmodule

// File: rtl/plk_burn_timer.sv
module plk_burn_timer #(
   parameter int WR_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(WR_CYCLES + 1);
   localparam logic [CW-1:0] LOAD_V = CW'(WR_CYCLES);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (go && cnt == '0) begin
         cnt <= LOAD_V;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   always_comb begin
      busy = (cnt != '0);
      done = (cnt == CW'(1));
   end

   // R4
   go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy) |=> busy);
endmodule

// File: rtl/plk_wr_gate.sv
module plk_wr_gate #(
   parameter int AW         = 8,
   parameter int PROT_LIMIT = 128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic [AW-1:0] wr_addr,
   input  logic          wp_pin,
   input  logic          busy,
   input  logic          locked,
   output logic          arr_wr_en
);
   logic in_low;

   generate
      if ((PROT_LIMIT & (PROT_LIMIT - 1)) == 0) begin : g_pow2
         localparam int LB = $clog2(PROT_LIMIT);
         if (LB >= AW) begin : g_all
            assign in_low = 1'b1;
         end else begin : g_slice
            assign in_low = ~|wr_addr[AW-1:LB];
         end
      end else begin : g_cmp
         localparam logic [AW:0] LIM_V = (AW+1)'(PROT_LIMIT);
         assign in_low = ({1'b0, wr_addr} < LIM_V);
      end
   endgenerate

   always_comb begin
      arr_wr_en = wr_req && !wp_pin && !busy && !(locked && in_low);
   end

   // R7
   wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_pin |-> !arr_wr_en);

   // R9
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !arr_wr_en);

   // R8
   low_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && arr_wr_en) |-> ({1'b0, wr_addr} >= (AW+1)'(PROT_LIMIT)));
endmodule

// File: rtl/perm_lock_ctrl.sv
module perm_lock_ctrl
   import plk_pkg::*;
#(
   parameter int                AW         = 8,
   parameter int                PROT_LIMIT = 128,
   parameter int                WR_CYCLES  = 20,
   parameter logic [CODE_W-1:0] DEV_CODE   = 4'b0110
) (
   input  logic                  clk,
   input  logic                  por_n,
   input  logic                  rst_n,
   input  logic [STRAP_W-1:0]    dev_strap,
   input  logic                  wp_pin,
   input  logic                  addr_vld,
   input  logic [DEV_BYTE_W-1:0] addr_byte,
   input  logic                  word_vld,
   input  logic                  data_vld,
   input  logic                  stop_det,
   input  logic                  start_det,
   input  logic                  wr_req,
   input  logic [AW-1:0]         wr_addr,
   output logic                  rsp_vld,
   output logic                  rsp_ack,
   output logic                  arr_wr_en,
   output logic                  busy,
   output logic                  locked
);
   generate
      if (AW < 1) begin : g_bad_aw
         $error("AW must be at least 1");
      end
      if (PROT_LIMIT < 1 || PROT_LIMIT > (1 << AW)) begin : g_bad_lim
         $error("PROT_LIMIT must lie in 1 .. 2**AW");
      end
      if (WR_CYCLES < 1) begin : g_bad_wrc
         $error("WR_CYCLES must be at least 1");
      end
   endgenerate

   logic hit, is_wr, ack_ok, burn_go, burn_done;

   plk_addr_dec #(.DEV_CODE(DEV_CODE)) u_dec (
      .addr_byte (addr_byte),
      .dev_strap (dev_strap),
      .hit       (hit),
      .is_wr     (is_wr)
   );

   assign ack_ok = !locked && !busy;

   plk_cmd_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_vld  (addr_vld),
      .hit       (hit),
      .is_wr     (is_wr),
      .ack_ok    (ack_ok),
      .word_vld  (word_vld),
      .data_vld  (data_vld),
      .stop_det  (stop_det),
      .start_det (start_det),
      .wp_pin    (wp_pin),
      .burn_go   (burn_go)
   );

   plk_burn_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (burn_go),
      .busy  (busy),
      .done  (burn_done)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         locked <= 1'b0;
      end else if (burn_done) begin
         locked <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld <= 1'b0;
         rsp_ack <= 1'b0;
      end else begin
         rsp_vld <= addr_vld && hit;
         rsp_ack <= addr_vld && hit && ack_ok;
      end
   end

   plk_wr_gate #(.AW(AW), .PROT_LIMIT(PROT_LIMIT)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (wr_req),
      .wr_addr   (wr_addr),
      .wp_pin    (wp_pin),
      .busy      (busy),
      .locked    (locked),
      .arr_wr_en (arr_wr_en)
   );

   // R10
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      locked |=> locked);

   // R4
   lock_rise_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $rose(locked) |-> $past(busy));

   // R3
   locked_nack_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (addr_vld && hit && locked) |=> (rsp_vld && !rsp_ack));

   // R9
   busy_nack_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (addr_vld && hit && busy) |=> !rsp_ack);

   // R2
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_vld |=> !rsp_vld);
endmodule

// File: tb/sim_perm_lock_ctrl.sv
module sim_perm_lock_ctrl;
   localparam int AW = 8;
   localparam int PL = 128;
   localparam int WRC = 20;
   localparam logic [3:0] CODE  = 4'b0110;
   localparam logic [2:0] STRAP = 3'b101;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic por_n, rst_n, wp_pin, addr_vld, word_vld, data_vld, stop_det, start_det, wr_req;
   logic [2:0]    dev_strap;
   logic [7:0]    addr_byte;
   logic [AW-1:0] wr_addr;
   logic rsp_vld, rsp_ack, arr_wr_en, busy, locked;

   perm_lock_ctrl #(.AW(AW), .PROT_LIMIT(PL), .WR_CYCLES(WRC), .DEV_CODE(CODE)) u0 (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .dev_strap(dev_strap), .wp_pin(wp_pin),
      .addr_vld(addr_vld), .addr_byte(addr_byte), .word_vld(word_vld), .data_vld(data_vld),
      .stop_det(stop_det), .start_det(start_det), .wr_req(wr_req), .wr_addr(wr_addr),
      .rsp_vld(rsp_vld), .rsp_ack(rsp_ack), .arr_wr_en(arr_wr_en), .busy(busy), .locked(locked)
   );

   int n_run = 0;
   int n_fail = 0;
   bit fin = 1'b0;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic exp_gate(input logic [AW-1:0] a, input logic wp, input logic lk, input logic bz);
      return !wp && !bz && !(lk && a < PL);
   endfunction

   function automatic logic [7:0] spec(input logic rw);
      return {CODE, STRAP, rw};
   endfunction

   task automatic p_addr(input logic [7:0] b);
      addr_byte = b; addr_vld = 1'b1;
      @(negedge clk);
      addr_vld = 1'b0;
   endtask
   task automatic p_word();
      word_vld = 1'b1; @(negedge clk); word_vld = 1'b0;
   endtask
   task automatic p_data();
      data_vld = 1'b1; @(negedge clk); data_vld = 1'b0;
   endtask
   task automatic p_stop();
      stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
   endtask
   task automatic p_start();
      start_det = 1'b1; @(negedge clk); start_det = 1'b0;
   endtask

   task automatic gate_sweep(input string rq, input logic lk, input int n);
      for (int i = 0; i < n; i++) begin
         wr_addr = AW'($urandom);
         if (i % 4 == 0) wr_addr = AW'(PL - 1 + (i % 8) / 4);
         wp_pin = 1'(($urandom % 3) == 0);
         wr_req = 1'b1;
         #1;
         chk(rq, arr_wr_en, exp_gate(wr_addr, wp_pin, lk, 1'b0));
         @(negedge clk);
      end
      wr_req = 1'b0; wp_pin = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         n_run++; n_fail++;
         $display("FAIL watchdog all requirements actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      logic ev;
      void'($urandom(32'h1C0FFEE));
      por_n = 0; rst_n = 0; wp_pin = 0; addr_vld = 0; word_vld = 0; data_vld = 0;
      stop_det = 0; start_det = 0; wr_req = 0; addr_byte = 0; wr_addr = 0; dev_strap = STRAP;
      repeat (3) @(negedge clk);
      por_n = 1; rst_n = 1;
      @(negedge clk);
      chk("R1 locked after init", locked, 0);
      chk("R1 busy after reset", busy, 0);
      chk("R1 rsp_vld after reset", rsp_vld, 0);

      // R2 R3 status query while unlocked
      p_addr(spec(1'b1));
      chk("R2 rsp_vld special", rsp_vld, 1);
      chk("R3 ack unlocked", rsp_ack, 1);
      chk("R3 query leaves lock", locked, 0);
      chk("R3 query leaves busy", busy, 0);
      @(negedge clk);
      chk("R2 rsp_vld one cycle", rsp_vld, 0);

      p_addr({CODE, ~STRAP, 1'b0});
      chk("R2 wrong strap no rsp", rsp_vld, 0);

      // R2 random device bytes
      for (int i = 0; i < 60; i++) begin
         b = 8'($urandom);
         if (i % 5 == 0) b = {CODE, STRAP, b[0]};
         ev = (b[7:4] == CODE) && (b[3:1] == STRAP);
         p_addr(b);
         chk("R2 random decode", rsp_vld, ev);
         if (ev) chk("R3 random ack unlocked", rsp_ack, 1);
      end
      p_start();
      chk("R5 random traffic no busy", busy, 0);

      // R7 R8 gate before lock
      gate_sweep("R8 gate unlocked", 1'b0, 100);
      wp_pin = 1'b1; wr_req = 1'b1; wr_addr = 8'hC3; #1;
      chk("R7 wp high blocks", arr_wr_en, 0);
      @(negedge clk); wp_pin = 1'b0; wr_req = 1'b0;

      // R5 aborts
      p_addr(spec(1'b0)); p_word(); p_stop();
      chk("R5 stop before data", busy, 0);
      p_addr(spec(1'b0)); p_word(); p_data(); p_start(); p_stop();
      chk("R5 start aborts", busy, 0);
      p_addr(spec(1'b0)); p_word(); p_data(); p_addr(8'hA0); p_stop();
      chk("R5 new address aborts", busy, 0);

      // R6 wp high mid-command, then exactly on the stop cycle
      p_addr(spec(1'b0)); wp_pin = 1'b1; p_word(); wp_pin = 1'b0; p_data(); p_stop();
      chk("R6 wp during word", busy, 0);
      p_addr(spec(1'b0)); p_word(); p_data(); wp_pin = 1'b1; p_stop(); wp_pin = 1'b0;
      chk("R6 wp on stop cycle", busy, 0);
      @(negedge clk);
      chk("R6 no lock", locked, 0);

      // R4 full command
      p_addr(spec(1'b0));
      chk("R4 command ack", rsp_ack, 1);
      p_word(); p_data(); p_stop();
      chk("R4 busy after stop", busy, 1);
      p_addr(spec(1'b1));
      chk("R9 rsp during busy", rsp_vld, 1);
      chk("R9 nack during busy", rsp_ack, 0);
      wr_req = 1'b1; wr_addr = 8'hF0; #1;
      chk("R9 gate closed during busy", arr_wr_en, 0);
      repeat (WRC - 2) @(negedge clk);
      chk("R4 busy last cycle", busy, 1);
      chk("R4 not yet locked", locked, 0);
      @(negedge clk);
      chk("R4 busy ends", busy, 0);
      chk("R4 locked set", locked, 1);
      chk("R8 high addr open after lock", arr_wr_en, 1);
      wr_req = 1'b0;

      // R3 after lock
      p_addr(spec(1'b1));
      chk("R3 status nack locked", rsp_ack, 0);
      p_addr(spec(1'b0));
      chk("R3 write nack locked", rsp_ack, 0);
      p_word(); p_data(); p_stop();
      chk("R3 repeat command no busy", busy, 0);

      // R8 gate after lock
      gate_sweep("R8 gate locked", 1'b1, 100);

      // R10 sticky through functional reset
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
      chk("R10 lock survives rst_n", locked, 1);
      wr_req = 1'b1; wr_addr = 8'h05; #1;
      chk("R10 low range still closed", arr_wr_en, 0);
      @(negedge clk); wr_req = 1'b0;
      por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
      chk("R10 por clears lock", locked, 0);
      wr_req = 1'b1; wr_addr = 8'h05; #1;
      chk("R8 low range open when unlocked", arr_wr_en, 1);
      @(negedge clk); wr_req = 1'b0;

      fin = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule